// File: doc/BRIEF.md
# Cache Line Lock Controller

This block keeps critical lines resident in three small set-associative caches: an instruction cache, a data cache and a secondary cache. Each cache is 4-way with 64 sets. Only way 0 (way A) and way 1 (way B) of a set can be pinned, and each has its own lock bit. Software does not set lock bits directly. It writes a control word that turns on locking for a cache and names the target way. Every later fill of that cache that uses the matching trigger then pins the filled line in the chosen way.

A miss request asks for a victim way in a given set. The block answers one cycle later. It scans round-robin from a per-cache pointer and skips locked ways, so a pinned line is never chosen. An explicit invalidate of a line drops its lock. A query port shows the two lock bits of any set.

The answer path is a two-state machine. ST_IDLE means no answer is pending. An accepted miss moves it to ST_RESP (transition IDLE_TO_RESP), where the victim is presented for one cycle. Another accepted miss keeps it in ST_RESP (RESP_HOLD). Without a miss, ST_RESP returns to ST_IDLE (RESP_TO_IDLE) and ST_IDLE stays put (IDLE_HOLD).

Top module: `cache_lock_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) clears every lock bit and every round-robin pointer to 0, and leaves `victim_valid` low.
- R2: A control write (`cfg_we`) stores the following bits of `cfg_wdata`: bit 27 enables locking in the instruction cache, bit 26 in the data cache and bit 25 in the secondary cache. Bit 28 selects the target way: 0 selects way 0 and 1 selects way 1. All other bits are ignored. The stored value governs fills from the cycle after the write.
- R3: A fill with `fill_cache`=0 (instruction) and `fill_kind`=0 (instruction-fill operation) sets the lock bit of the selected way at `fill_index`, provided bit 27 is set.
- R4: A fill with `fill_cache`=1 (data) and `fill_kind`=1 (load/store fill) sets the selected lock bit, provided bit 26 is set.
- R5: A fill with `fill_cache`=2 (secondary) sets the selected lock bit for either `fill_kind`, provided bit 25 is set.
- R6: A fill whose cache has locking disabled changes no lock bit. The same holds for an instruction cache fill with `fill_kind`=1 and for a data cache fill with `fill_kind`=0.
- R7: Locking is per line. A fill changes only the one lock bit of its own cache, set and selected way, and ways 2 and 3 have no lock bit.
- R8: An invalidate (`inval_valid`) of way 0 or way 1 clears that lock bit. An invalidate of way 2 or way 3 has no effect. When an invalidate and a fill hit the same lock bit in the same cycle, the invalidate wins.
- R9: A miss with `miss_cache` 0 to 2 is answered in the next cycle with `victim_valid`=1 and a `victim_way` that was not locked in that set when the miss was accepted.
- R10: Each cache has a 2-bit round-robin pointer. The victim is the first unlocked way found by scanning from the pointer upward, modulo 4. After the choice, the pointer becomes the victim plus 1.
- R11: `qry_lock` shows {way 1 lock, way 0 lock} for `qry_cache`/`qry_index` without delay. Cache code 3 selects no cache: queries return 0, and fills, invalidates and misses that carry it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word; bits 28..25 are used |
| fill_valid | input | 1 | Fill event |
| fill_kind | input | 1 | 0 instruction-fill operation, 1 load/store fill |
| fill_cache | input | 2 | Cache code: 0 instruction, 1 data, 2 secondary |
| fill_index | input | 6 | Set index of the fill |
| inval_valid | input | 1 | Line invalidate event |
| inval_cache | input | 2 | Cache code of the invalidate |
| inval_index | input | 6 | Set index of the invalidate |
| inval_way | input | 2 | Way being invalidated |
| miss_valid | input | 1 | Victim request |
| miss_cache | input | 2 | Cache code of the miss |
| miss_index | input | 6 | Set index of the miss |
| qry_cache | input | 2 | Cache code to observe |
| qry_index | input | 6 | Set index to observe |
| qry_lock | output | 2 | {way 1, way 0} lock bits of the queried set |
| victim_valid | output | 1 | Victim answer valid |
| victim_way | output | 2 | Chosen victim way |

## Verification
The hardest case is a set where both lockable ways are pinned and the pointer of its cache points at one of them. Only then does the scan have to step past two locked entries. The bench reaches it by first running five misses on one unlocked data set to walk the pointer around. It then pins way 0 and way 1 of that set through two enabled load/store fills with opposite way selects. Three more misses then check that the answers skip to way 2 or way 3, including one that wraps from pointer 0.

// File: rtl/cache_lock_pkg.sv
`timescale 1ns/1ps
package cache_lock_pkg;
    typedef enum logic [1:0] {
        CID_INST = 2'd0,
        CID_DATA = 2'd1,
        CID_SEC  = 2'd2,
        CID_NONE = 2'd3
    } cache_id_e;

    typedef enum logic {
        FK_IFILL = 1'b0,
        FK_LDST  = 1'b1
    } fill_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } vsel_state_e;

    typedef struct packed {
        logic sel_b;
        logic en_i;
        logic en_d;
        logic en_s;
    } lock_cfg_t;

    localparam int NCACHE   = 3;
    localparam int CFG_W    = 32;
    localparam int BIT_SEL  = 28;
    localparam int BIT_EN_I = 27;
    localparam int BIT_EN_D = 26;
    localparam int BIT_EN_S = 25;
    localparam int LOCK_WAYS = 2;
endpackage

// File: rtl/lock_cfg_reg.sv
`timescale 1ns/1ps
module lock_cfg_reg
    import cache_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output lock_cfg_t        cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.sel_b <= wdata[BIT_SEL];
            cfg_q.en_i  <= wdata[BIT_EN_I];
            cfg_q.en_d  <= wdata[BIT_EN_D];
            cfg_q.en_s  <= wdata[BIT_EN_S];
        end
    end
endmodule

// File: rtl/lock_bit_array.sv
`timescale 1ns/1ps
module lock_bit_array
    import cache_lock_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      set_en,
    input  logic [IDX_W-1:0]          set_idx,
    input  logic                      set_way,
    input  logic                      clr_en,
    input  logic [IDX_W-1:0]          clr_idx,
    input  logic                      clr_way,
    input  logic [IDX_W-1:0]          rd_idx_a,
    output logic [LOCK_WAYS-1:0]      rd_lock_a,
    input  logic [IDX_W-1:0]          rd_idx_b,
    output logic [LOCK_WAYS-1:0]      rd_lock_b,
    output logic [SETS*LOCK_WAYS-1:0] flat_o
);
    logic [LOCK_WAYS-1:0] lk_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) lk_q[s] <= '0;
        end else begin
            if (set_en) lk_q[set_idx][set_way] <= 1'b1;
            // clear is written last so it wins on a collision
            if (clr_en) lk_q[clr_idx][clr_way] <= 1'b0;
        end
    end

    assign rd_lock_a = lk_q[rd_idx_a];
    assign rd_lock_b = lk_q[rd_idx_b];

    for (genvar s = 0; s < SETS; s++) begin : g_flat
        assign flat_o[s*LOCK_WAYS +: LOCK_WAYS] = lk_q[s];
    end
endmodule

// File: rtl/victim_picker.sv
`timescale 1ns/1ps
module victim_picker
    import cache_lock_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [LOCK_WAYS-1:0] locks,
    input  logic [WAY_W-1:0]     start,
    output logic [WAY_W-1:0]     pick
);
    always_comb begin
        logic             found;
        logic [WAY_W-1:0] cand;
        logic             locked;
        found = 1'b0;
        pick  = start;
        for (int k = 0; k < WAYS; k++) begin
            cand   = start + WAY_W'(k);
            locked = (cand < WAY_W'(LOCK_WAYS)) ? locks[cand[0]] : 1'b0;
            if (!found && !locked) begin
                pick  = cand;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_lock_ctrl.sv
`timescale 1ns/1ps
module cache_lock_ctrl
    import cache_lock_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             fill_valid,
    input  logic             fill_kind,
    input  logic [1:0]       fill_cache,
    input  logic [IDX_W-1:0] fill_index,
    input  logic             inval_valid,
    input  logic [1:0]       inval_cache,
    input  logic [IDX_W-1:0] inval_index,
    input  logic [WAY_W-1:0] inval_way,
    input  logic             miss_valid,
    input  logic [1:0]       miss_cache,
    input  logic [IDX_W-1:0] miss_index,
    input  logic [1:0]       qry_cache,
    input  logic [IDX_W-1:0] qry_index,
    output logic [1:0]       qry_lock,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);
    localparam int SLICE_W = SETS * LOCK_WAYS;
    localparam int FLAT_W  = NCACHE * SLICE_W;

    lock_cfg_t               cfg_q;
    logic [LOCK_WAYS-1:0]    miss_lk [NCACHE];
    logic [LOCK_WAYS-1:0]    qry_lk  [NCACHE];
    logic [FLAT_W-1:0]       lock_flat;
    logic [WAY_W-1:0]        rr_q    [NCACHE];
    logic [LOCK_WAYS-1:0]    miss_locks;
    logic [WAY_W-1:0]        rr_start;
    logic [WAY_W-1:0]        pick;
    logic [WAY_W-1:0]        victim_q;
    logic                    miss_go;
    vsel_state_e             st_q, st_d;

    lock_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar c = 0; c < NCACHE; c++) begin : g_cache
        logic trig_ok;
        logic set_en;
        logic clr_en;
        if (c == int'(CID_INST)) begin : g_trig_i
            assign trig_ok = cfg_q.en_i && (fill_kind == FK_IFILL);
        end else if (c == int'(CID_DATA)) begin : g_trig_d
            assign trig_ok = cfg_q.en_d && (fill_kind == FK_LDST);
        end else begin : g_trig_s
            assign trig_ok = cfg_q.en_s;
        end
        assign set_en = fill_valid && (fill_cache == 2'(c)) && trig_ok;
        assign clr_en = inval_valid && (inval_cache == 2'(c))
                     && (inval_way < WAY_W'(LOCK_WAYS));

        lock_bit_array #(.SETS(SETS), .IDX_W(IDX_W)) u_arr (
            .clk       (clk),
            .rst       (rst),
            .set_en    (set_en),
            .set_idx   (fill_index),
            .set_way   (cfg_q.sel_b),
            .clr_en    (clr_en),
            .clr_idx   (inval_index),
            .clr_way   (inval_way[0]),
            .rd_idx_a  (miss_index),
            .rd_lock_a (miss_lk[c]),
            .rd_idx_b  (qry_index),
            .rd_lock_b (qry_lk[c]),
            .flat_o    (lock_flat[c*SLICE_W +: SLICE_W])
        );
    end

    assign miss_go    = miss_valid && (miss_cache != CID_NONE);
    assign miss_locks = (miss_cache != CID_NONE) ? miss_lk[miss_cache] : '0;
    assign rr_start   = (miss_cache != CID_NONE) ? rr_q[miss_cache] : '0;
    assign qry_lock   = (qry_cache != CID_NONE) ? qry_lk[qry_cache] : '0;

    victim_picker #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .locks (miss_locks),
        .start (rr_start),
        .pick  (pick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state: IDLE_HOLD, IDLE_TO_RESP, RESP_HOLD, RESP_TO_IDLE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = miss_go ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = miss_go ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // victim register and round-robin pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            victim_q <= '0;
            for (int c = 0; c < NCACHE; c++) rr_q[c] <= '0;
        end else if (miss_go) begin
            victim_q         <= pick;
            rr_q[miss_cache] <= pick + WAY_W'(1);
        end
    end

    // outputs
    always_comb begin
        victim_valid = (st_q == ST_RESP);
        victim_way   = victim_q;
    end
endmodule

// File: rtl/cache_lock_ctrl_chk.sv
`timescale 1ns/1ps
module cache_lock_ctrl_chk
    import cache_lock_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS),
    parameter int FLAT_W = NCACHE * SETS * LOCK_WAYS
) (
    input logic             clk,
    input logic             rst,
    input logic             fill_valid,
    input logic             fill_kind,
    input logic [1:0]       fill_cache,
    input logic [IDX_W-1:0] fill_index,
    input logic             inval_valid,
    input logic [1:0]       inval_cache,
    input logic [IDX_W-1:0] inval_index,
    input logic [WAY_W-1:0] inval_way,
    input logic             miss_valid,
    input logic [1:0]       miss_cache,
    input logic [IDX_W-1:0] miss_index,
    input logic [1:0]       qry_lock,
    input logic             victim_valid,
    input logic [WAY_W-1:0] victim_way,
    input lock_cfg_t        cfg_q,
    input logic [FLAT_W-1:0] lock_flat
);
    int fpos, ipos, mpos;
    logic inv_hits_fill;
    logic [1:0] miss_locks;

    always_comb begin
        fpos = (int'(fill_cache) * SETS + int'(fill_index)) * LOCK_WAYS + int'(cfg_q.sel_b);
        ipos = (int'(inval_cache) * SETS + int'(inval_index)) * LOCK_WAYS + int'(inval_way[0]);
        mpos = (int'(miss_cache) * SETS + int'(miss_index)) * LOCK_WAYS;
        if (fpos >= FLAT_W) fpos = 0;
        if (ipos >= FLAT_W) ipos = 0;
        if (mpos >= FLAT_W - 1) mpos = 0;
        inv_hits_fill = inval_valid && (inval_cache == fill_cache)
                     && (inval_index == fill_index)
                     && (inval_way == WAY_W'(cfg_q.sel_b));
        miss_locks = lock_flat[mpos +: 2];
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!victim_valid && qry_lock == 2'b00));

    a_r3_ifill_locks: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_cache == 2'd0 && fill_kind == 1'b0 && cfg_q.en_i && !inv_hits_fill)
        |=> lock_flat[$past(fpos)]);

    a_r4_ldst_locks: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_cache == 2'd1 && fill_kind == 1'b1 && cfg_q.en_d && !inv_hits_fill)
        |=> lock_flat[$past(fpos)]);

    a_r8_inval_clears: assert property (@(posedge clk) disable iff (rst)
        (inval_valid && inval_cache != 2'd3 && inval_way < WAY_W'(LOCK_WAYS))
        |=> !lock_flat[$past(ipos)]);

    a_r9_answer_next: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_cache != 2'd3) |=> victim_valid);

    a_r9_victim_unlocked: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> !((victim_way == WAY_W'(0) && $past(miss_locks[0]))
                        || (victim_way == WAY_W'(1) && $past(miss_locks[1]))));
endmodule

bind cache_lock_ctrl cache_lock_ctrl_chk #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fill_valid   (fill_valid),
    .fill_kind    (fill_kind),
    .fill_cache   (fill_cache),
    .fill_index   (fill_index),
    .inval_valid  (inval_valid),
    .inval_cache  (inval_cache),
    .inval_index  (inval_index),
    .inval_way    (inval_way),
    .miss_valid   (miss_valid),
    .miss_cache   (miss_cache),
    .miss_index   (miss_index),
    .qry_lock     (qry_lock),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .cfg_q        (cfg_q),
    .lock_flat    (lock_flat)
);

// File: tb/cache_lock_ctrl_bench.sv
`timescale 1ns/1ps
module cache_lock_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic       fill_valid = 1'b0, fill_kind = 1'b0;
    logic [1:0] fill_cache = '0;
    logic [5:0] fill_index = '0;
    logic       inval_valid = 1'b0;
    logic [1:0] inval_cache = '0;
    logic [5:0] inval_index = '0;
    logic [1:0] inval_way = '0;
    logic       miss_valid = 1'b0;
    logic [1:0] miss_cache = '0;
    logic [5:0] miss_index = '0;
    logic [1:0] qry_cache = '0;
    logic [5:0] qry_index = '0;
    logic [1:0] qry_lock;
    logic       victim_valid;
    logic [1:0] victim_way;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [31:0] EN_I = 32'h0800_0000;
    localparam logic [31:0] EN_D = 32'h0400_0000;
    localparam logic [31:0] EN_S = 32'h0200_0000;
    localparam logic [31:0] SELB = 32'h1000_0000;

    always #5 clk = ~clk;

    cache_lock_ctrl u_cache_lock_ctrl (.*);

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_cfg(logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic do_fill(logic [1:0] c, logic k, logic [5:0] idx);
        @(negedge clk); fill_valid = 1'b1; fill_cache = c; fill_kind = k; fill_index = idx;
        @(negedge clk); fill_valid = 1'b0;
    endtask

    task automatic do_inval(logic [1:0] c, logic [5:0] idx, logic [1:0] w);
        @(negedge clk); inval_valid = 1'b1; inval_cache = c; inval_index = idx; inval_way = w;
        @(negedge clk); inval_valid = 1'b0;
    endtask

    task automatic look(string req, logic [1:0] c, logic [5:0] idx, int exp);
        qry_cache = c; qry_index = idx; #1;
        chk(req, $sformatf("lock c%0d s%0d", c, idx), int'(qry_lock), exp);
    endtask

    task automatic do_miss(string req, logic [1:0] c, logic [5:0] idx, int exp_way);
        @(negedge clk); miss_valid = 1'b1; miss_cache = c; miss_index = idx;
        @(negedge clk); miss_valid = 1'b0; #1;
        chk(req, "victim_valid", int'(victim_valid), 1);
        chk(req, $sformatf("victim c%0d s%0d", c, idx), int'(victim_way), exp_way);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1", "victim_valid after reset", int'(victim_valid), 0);
        look("R1", 2'd0, 6'd3, 0);
        look("R1", 2'd2, 6'd63, 0);
    endtask

    task automatic t_icache();
        do_cfg(EN_I);
        do_fill(2'd0, 1'b0, 6'd3);
        look("R3", 2'd0, 6'd3, 1);
        do_fill(2'd0, 1'b1, 6'd4);
        look("R6", 2'd0, 6'd4, 0);
        do_cfg(EN_I | SELB);
        do_fill(2'd0, 1'b0, 6'd3);
        look("R2", 2'd0, 6'd3, 3);
        look("R7", 2'd0, 6'd2, 0);
        look("R7", 2'd1, 6'd3, 0);
        look("R11", 2'd3, 6'd3, 0);
    endtask

    task automatic t_dcache();
        do_cfg(EN_D);
        do_fill(2'd1, 1'b1, 6'd10);
        look("R4", 2'd1, 6'd10, 1);
        do_fill(2'd1, 1'b0, 6'd11);
        look("R6", 2'd1, 6'd11, 0);
        do_fill(2'd0, 1'b0, 6'd12);
        look("R6", 2'd0, 6'd12, 0);
    endtask

    task automatic t_secondary();
        do_cfg(EN_S | SELB);
        do_fill(2'd2, 1'b0, 6'd20);
        look("R5", 2'd2, 6'd20, 2);
        do_fill(2'd2, 1'b1, 6'd21);
        look("R5", 2'd2, 6'd21, 2);
    endtask

    task automatic t_cfg_other_bits();
        do_cfg(32'hE1FF_FFFF);
        do_fill(2'd1, 1'b1, 6'd30);
        do_fill(2'd2, 1'b0, 6'd30);
        look("R2", 2'd1, 6'd30, 0);
        look("R2", 2'd2, 6'd30, 0);
    endtask

    task automatic t_inval();
        do_inval(2'd0, 6'd3, 2'd1);
        look("R8", 2'd0, 6'd3, 1);
        do_inval(2'd0, 6'd3, 2'd2);
        look("R8", 2'd0, 6'd3, 1);
        do_cfg(EN_D);
        @(negedge clk);
        fill_valid = 1'b1; fill_cache = 2'd1; fill_kind = 1'b1; fill_index = 6'd40;
        inval_valid = 1'b1; inval_cache = 2'd1; inval_index = 6'd40; inval_way = 2'd0;
        @(negedge clk);
        fill_valid = 1'b0; inval_valid = 1'b0;
        look("R8", 2'd1, 6'd40, 0);
    endtask

    task automatic t_round_robin();
        do_miss("R10", 2'd1, 6'd5, 0);
        do_miss("R10", 2'd1, 6'd5, 1);
        do_miss("R10", 2'd1, 6'd5, 2);
        do_miss("R10", 2'd1, 6'd5, 3);
        do_miss("R10", 2'd1, 6'd5, 0);
        do_cfg(EN_D);
        do_fill(2'd1, 1'b1, 6'd5);
        do_cfg(EN_D | SELB);
        do_fill(2'd1, 1'b1, 6'd5);
        look("R7", 2'd1, 6'd5, 3);
        do_miss("R9", 2'd1, 6'd5, 2);
        do_miss("R10", 2'd1, 6'd5, 3);
        do_miss("R9", 2'd1, 6'd5, 2);
        do_miss("R9", 2'd0, 6'd3, 1);
        @(negedge clk); miss_valid = 1'b1; miss_cache = 2'd3; miss_index = 6'd5;
        @(negedge clk); miss_valid = 1'b0; #1;
        chk("R11", "victim_valid for code 3", int'(victim_valid), 0);
    endtask

    initial begin
        t_reset();
        t_icache();
        t_dcache();
        t_secondary();
        t_cfg_other_bits();
        t_inval();
        t_round_robin();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule